// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is a calendar clock that sits in the top sixteen byte locations of a 17-bit byte-addressed map. It keeps seconds, minutes, hours (24-hour form), weekday, day of month, month, two-digit year and century, all as packed BCD bytes. A one-cycle strobe on the 1 Hz tick input advances the time by one second, with every carry through to the century handled inside the block.

Software never reads the live counters directly. It reads a visible copy that follows the live counters one cycle behind. Setting the freeze bit in the control byte holds that copy still, so a multi-byte read cannot see a carry halfway through. The live counters keep counting while the copy is held. Clearing the bit brings the copy up to date again. Every access outside the clock window is passed unchanged to an external memory port.

Top module: `rtcc_top`

## Requirements
- R1: An address whose upper 13 bits are all ones (1FFF0h–1FFFFh) selects the clock, and mem_ce, mem_we and mem_re stay low for it. Any other address drives mem_ce=ce, mem_we=ce&we and mem_re=ce&re. mem_addr and mem_wdata copy addr and wdata, and a read returns mem_rdata.
- R2: Clock byte offsets (addr[3:0]) are: 0h century, 8h control, 9h seconds, Ah minutes, Bh hours, Ch weekday, Dh date, Eh month, Fh year. The control byte reads back with only bit 6 (freeze) possibly set. Unassigned offsets read 00h and ignore writes. rdata is combinational from the current address while ce and re are high, and 00h otherwise.
- R3: After reset the time is 20 (century), 00 (year), 01 (month), 01 (date), 1 (weekday), 00:00:00, and freeze is clear.
- R4: Seconds and minutes count 00–59 in BCD (09 is followed by 10), and 59 wraps to 00 with a carry.
- R5: Hours count 00–23, and 23 wraps to 00 with a carry into the day.
- R6: The weekday steps once per day through 1 to 7, and 7 is followed by 1.
- R7: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R8: February ends at 29 when the two-digit year is divisible by 4, and at 28 otherwise.
- R9: The month wraps from 12 to 01. The year wraps from 99 to 00 and then increments the century (99 wraps to 00).
- R10: A write to a time byte replaces that field of the live time at the clock edge; a tick in the same cycle advances the other fields. The live time changes only on a tick or a write.
- R11: Writing 1 to control bit 6 freezes the visible copy. While frozen, reads return the values captured at the freeze even as ticks advance the live time.
- R12: When not frozen, the visible copy reloads from the live time every cycle, so it shows a change one cycle after it happens. After the freeze bit is cleared, the next cycle reloads the copy with the current live time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 17 | Byte address |
| ce | input | 1 | Chip enable |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| mem_ce | output | 1 | External memory enable |
| mem_we | output | 1 | External memory write enable |
| mem_re | output | 1 | External memory read enable |
| mem_addr | output | 17 | External memory address |
| mem_wdata | output | 8 | External memory write data |
| mem_rdata | input | 8 | External memory read data |

## Verification
The bench drives the time to the edge of each carry chain and ticks across it. It covers a single-digit BCD carry, 23:59:59 into midnight, the last day of a 30-day month, February in both a leap and a non-leap year, and New Year's Eve of year 99, which must also bump the century. A binary-counting or fixed-month design would show 0Ah, 31 April or 29 February of an odd year, and a design that missed the century carry would leave it at 20. For freezing, the bench ticks while the copy is held and expects the old seconds. After release it expects the new seconds. A copy tied to the live counters would show the change early, and one that failed to reload would stay stale. The window edge at 1FFEFh is checked so that a loose decode would steal memory accesses.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [3:0] {
        OFS_CENT = 4'h0,
        OFS_CTRL = 4'h8,
        OFS_SEC  = 4'h9,
        OFS_MIN  = 4'hA,
        OFS_HOUR = 4'hB,
        OFS_DOW  = 4'hC,
        OFS_DATE = 4'hD,
        OFS_MON  = 4'hE,
        OFS_YEAR = 4'hF
    } rtc_ofs_e;

    localparam int FRZ_BIT = 6;

    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // two-digit BCD year divisible by 4
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t time_at_reset(input logic [7:0] c);
        rtc_time_t t;
        t = '0;
        t.cent  = c;
        t.month = 8'h01;
        t.date  = 8'h01;
        t.dow   = 8'h01;
        return t;
    endfunction

    function automatic rtc_time_t advance(input rtc_time_t t);
        rtc_time_t r;
        r = t;
        if (t.sec != 8'h59) r.sec = bcd_next(t.sec);
        else begin
            r.sec = 8'h00;
            if (t.min != 8'h59) r.min = bcd_next(t.min);
            else begin
                r.min = 8'h00;
                if (t.hour != 8'h23) r.hour = bcd_next(t.hour);
                else begin
                    r.hour = 8'h00;
                    r.dow  = (t.dow == 8'h07) ? 8'h01 : bcd_next(t.dow);
                    if (t.date != last_day(t.month, t.year)) r.date = bcd_next(t.date);
                    else begin
                        r.date = 8'h01;
                        if (t.month != 8'h12) r.month = bcd_next(t.month);
                        else begin
                            r.month = 8'h01;
                            if (t.year != 8'h99) r.year = bcd_next(t.year);
                            else begin
                                r.year = 8'h00;
                                r.cent = (t.cent == 8'h99) ? 8'h00 : bcd_next(t.cent);
                            end
                        end
                    end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rtcc_live.sv
module rtcc_live
    import rtcc_pkg::*;
#(
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      fld_wr,
    input  logic [3:0] fld_ofs,
    input  logic [7:0] fld_data,
    output rtc_time_t live
);
    rtc_time_t nxt;

    always_comb begin
        nxt = tick ? advance(live) : live;
        if (fld_wr) begin
            case (fld_ofs)
                OFS_CENT: nxt.cent  = fld_data;
                OFS_SEC:  nxt.sec   = fld_data;
                OFS_MIN:  nxt.min   = fld_data;
                OFS_HOUR: nxt.hour  = fld_data;
                OFS_DOW:  nxt.dow   = fld_data;
                OFS_DATE: nxt.date  = fld_data;
                OFS_MON:  nxt.month = fld_data;
                OFS_YEAR: nxt.year  = fld_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) live <= time_at_reset(RESET_CENT);
        else     live <= nxt;
    end
endmodule

// File: rtl/rtcc_view.sv
module rtcc_view
    import rtcc_pkg::*;
#(
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ctrl_wr,
    input  logic      ctrl_frz,
    input  rtc_time_t live,
    output rtc_time_t view,
    output logic      frz
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frz  <= 1'b0;
            view <= time_at_reset(RESET_CENT);
        end else begin
            if (ctrl_wr) frz <= ctrl_frz;
            if (!frz)    view <= live;
        end
    end
endmodule

// File: rtl/rtcc_decode.sv
module rtcc_decode
    import rtcc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce,
    input  logic              we,
    input  logic              re,
    input  logic [7:0]        wdata,
    input  rtc_time_t         view,
    input  logic              frz,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        rdata,
    output logic              fld_wr,
    output logic              ctrl_wr,
    output logic [3:0]        ofs,
    output logic              mem_ce,
    output logic              mem_we,
    output logic              mem_re
);
    localparam int HI_W = ADDR_W - 4;

    logic       hit;
    logic       bus_wr;
    logic [7:0] reg_byte;

    assign hit     = (addr[ADDR_W-1:4] == {HI_W{1'b1}});
    assign ofs     = addr[3:0];
    assign bus_wr  = ce && we && hit;
    assign ctrl_wr = bus_wr && (ofs == OFS_CTRL);
    assign fld_wr  = bus_wr && (ofs != OFS_CTRL);
    assign mem_ce  = ce && !hit;
    assign mem_we  = ce && we && !hit;
    assign mem_re  = ce && re && !hit;

    always_comb begin
        reg_byte = 8'h00;
        case (ofs)
            OFS_CENT: reg_byte = view.cent;
            OFS_CTRL: reg_byte[FRZ_BIT] = frz;
            OFS_SEC:  reg_byte = view.sec;
            OFS_MIN:  reg_byte = view.min;
            OFS_HOUR: reg_byte = view.hour;
            OFS_DOW:  reg_byte = view.dow;
            OFS_DATE: reg_byte = view.date;
            OFS_MON:  reg_byte = view.month;
            OFS_YEAR: reg_byte = view.year;
            default:  reg_byte = 8'h00;
        endcase
    end

    assign rdata = (ce && re) ? (hit ? reg_byte : mem_rdata) : 8'h00;

    logic unused_wdata;
    assign unused_wdata = ^wdata;
endmodule

// File: rtl/rtcc_top.sv
module rtcc_top
    import rtcc_pkg::*;
#(
    parameter int         ADDR_W     = 17,
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce,
    input  logic              we,
    input  logic              re,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              tick_1hz,
    output logic              mem_ce,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    rtc_time_t  live_time;
    rtc_time_t  view_time;
    logic       freeze_q;
    logic       fld_wr;
    logic       ctrl_wr;
    logic [3:0] ofs;

    assign mem_addr  = addr;
    assign mem_wdata = wdata;

    rtcc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .ce(ce), .we(we), .re(re), .wdata(wdata),
        .view(view_time), .frz(freeze_q), .mem_rdata(mem_rdata),
        .rdata(rdata), .fld_wr(fld_wr), .ctrl_wr(ctrl_wr), .ofs(ofs),
        .mem_ce(mem_ce), .mem_we(mem_we), .mem_re(mem_re)
    );

    rtcc_live #(.RESET_CENT(RESET_CENT)) u_live (
        .clk(clk), .rst(rst), .tick(tick_1hz),
        .fld_wr(fld_wr), .fld_ofs(ofs), .fld_data(wdata),
        .live(live_time)
    );

    rtcc_view #(.RESET_CENT(RESET_CENT)) u_view (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_frz(wdata[FRZ_BIT]),
        .live(live_time), .view(view_time), .frz(freeze_q)
    );
endmodule

// File: rtl/rtcc_chk.sv
module rtcc_chk
    import rtcc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              ce,
    input logic              we,
    input logic              re,
    input logic              tick,
    input logic [7:0]        rdata,
    input logic              mem_ce,
    input logic              mem_we,
    input logic              frz,
    input rtc_time_t         live,
    input rtc_time_t         view
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = {{(ADDR_W-4){1'b1}}, 4'h8};

    // R1
    mem_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && (addr[ADDR_W-1:4] != {(ADDR_W-4){1'b1}})) |-> mem_ce);

    // R1
    win_block_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1:4] == {(ADDR_W-4){1'b1}}) |-> (!mem_ce && !mem_we));

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && re && addr == CTRL_ADDR) |-> (rdata == {1'b0, frz, 6'b0}));

    // R5
    hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !(ce && we) && live.hour == 8'h23 && live.min == 8'h59 && live.sec == 8'h59)
        |=> (live.hour == 8'h00));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(ce && we)) |=> $stable(live));

    // R11
    frz_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frz && $past(frz)) |-> $stable(view));

    // R12
    thaw_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frz) |=> (view == $past(live)));
endmodule

bind rtcc_top rtcc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .ce(ce), .we(we), .re(re),
    .tick(tick_1hz), .rdata(rdata), .mem_ce(mem_ce), .mem_we(mem_we),
    .frz(freeze_q), .live(live_time), .view(view_time)
);

// File: tb/tb_rtcc_top.sv
`timescale 1ns/1ps
module tb_rtcc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] addr = '0;
    logic        ce = 1'b0, we = 1'b0, re = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        tick_1hz = 1'b0;
    logic        mem_ce, mem_we, mem_re;
    logic [16:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    localparam logic [16:0] A_CENT = 17'h1FFF0, A_CTRL = 17'h1FFF8, A_SEC = 17'h1FFF9,
                            A_MIN = 17'h1FFFA, A_HOUR = 17'h1FFFB, A_DOW = 17'h1FFFC,
                            A_DATE = 17'h1FFFD, A_MON = 17'h1FFFE, A_YEAR = 17'h1FFFF;

    always #4 clk = ~clk;

    rtcc_top dut (
        .clk(clk), .rst(rst), .addr(addr), .ce(ce), .we(we), .re(re),
        .wdata(wdata), .rdata(rdata), .tick_1hz(tick_1hz),
        .mem_ce(mem_ce), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // monitor: pops expected bytes as reads appear
    always @(negedge clk) begin
        if (ce && re) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; ce = 1; we = 1;
        @(posedge clk); #1;
        ce = 0; we = 0;
    endtask

    task automatic rd(input logic [16:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        addr = a; ce = 1; re = 1;
        @(posedge clk); #1;
        ce = 0; re = 0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick_1hz = 1;
            @(posedge clk); #1; tick_1hz = 0;
        end
    endtask

    task automatic settime(input logic [7:0] c, y, mo, d, dw, h, mi, s);
        wr(A_CENT, c); wr(A_YEAR, y); wr(A_MON, mo); wr(A_DATE, d);
        wr(A_DOW, dw); wr(A_HOUR, h); wr(A_MIN, mi); wr(A_SEC, s);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R3 reset values
        rd(A_CENT, 8'h20, "R3 century"); rd(A_YEAR, 8'h00, "R3 year");
        rd(A_MON, 8'h01, "R3 month");    rd(A_DATE, 8'h01, "R3 date");
        rd(A_DOW, 8'h01, "R3 weekday");  rd(A_HOUR, 8'h00, "R3 hour");
        rd(A_SEC, 8'h00, "R3 sec");      rd(A_CTRL, 8'h00, "R3 control");

        // R4 digit carry and minute wrap
        settime(8'h20, 8'h25, 8'h06, 8'h10, 8'h03, 8'h08, 8'h14, 8'h09);
        tk(1); rd(A_SEC, 8'h10, "R4 sec 09->10");
        wr(A_SEC, 8'h59); tk(1);
        rd(A_SEC, 8'h00, "R4 sec wrap"); rd(A_MIN, 8'h15, "R4 min carry");

        // R5 hour carries: 19->20, 23->00
        settime(8'h20, 8'h25, 8'h06, 8'h10, 8'h03, 8'h19, 8'h59, 8'h59);
        tk(1); rd(A_HOUR, 8'h20, "R5 hour 19->20");

        // R9 R6 R5 full chain at year 99 end, weekday 7->1
        settime(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
        tk(1); rd(A_SEC, 8'h59, "R10 write then tick");
        tk(1);
        rd(A_HOUR, 8'h00, "R5 hour wrap"); rd(A_MIN, 8'h00, "R4 min wrap");
        rd(A_DOW, 8'h01, "R6 weekday 7->1"); rd(A_DATE, 8'h01, "R7 date wrap 31");
        rd(A_MON, 8'h01, "R9 month 12->01"); rd(A_YEAR, 8'h00, "R9 year 99->00");
        rd(A_CENT, 8'h21, "R9 century increment");

        // R7 30-day month
        settime(8'h20, 8'h25, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        tk(1); rd(A_DATE, 8'h01, "R7 april 30 wrap"); rd(A_MON, 8'h05, "R7 month 04->05");
        rd(A_DOW, 8'h03, "R6 weekday step");

        // R8 leap February
        settime(8'h20, 8'h24, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59);
        tk(1); rd(A_DATE, 8'h29, "R8 leap feb 28->29"); rd(A_MON, 8'h02, "R8 leap month holds");
        wr(A_HOUR, 8'h23); wr(A_MIN, 8'h59); wr(A_SEC, 8'h59);
        tk(1); rd(A_DATE, 8'h01, "R8 leap feb 29 wrap"); rd(A_MON, 8'h03, "R8 leap to march");

        // R8 non-leap February
        settime(8'h20, 8'h23, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59);
        tk(1); rd(A_DATE, 8'h01, "R8 nonleap feb 28 wrap"); rd(A_MON, 8'h03, "R8 nonleap march");

        // R11 freeze
        settime(8'h20, 8'h25, 8'h01, 8'h05, 8'h01, 8'h10, 8'h00, 8'h00);
        wr(A_CTRL, 8'h40);
        rd(A_CTRL, 8'h40, "R2 control readback");
        tk(5);
        rd(A_SEC, 8'h00, "R11 frozen sec");
        rd(A_MIN, 8'h00, "R11 frozen min");
        // R12 release reloads
        wr(A_CTRL, 8'h00);
        rd(A_SEC, 8'h05, "R12 reload after thaw");
        rd(A_CTRL, 8'h00, "R12 control cleared");

        // R2 unassigned offset
        wr(17'h1FFF3, 8'hAB);
        rd(17'h1FFF3, 8'h00, "R2 unused offset reads zero");
        rd(A_SEC, 8'h05, "R2 unused write no effect");

        // R1 passthrough
        @(posedge clk); #1;
        addr = 17'h00123; wdata = 8'h5A; ce = 1; we = 1;
        @(negedge clk);
        check("R1 mem_ce", mem_ce, 1); check("R1 mem_we", mem_we, 1);
        check("R1 mem_addr", mem_addr, 17'h00123); check("R1 mem_wdata", mem_wdata, 8'h5A);
        @(posedge clk); #1; ce = 0; we = 0;
        @(posedge clk); #1;
        addr = 17'h1FFF9; wdata = 8'h33; ce = 1; we = 1;
        @(negedge clk);
        check("R1 window blocks mem_ce", mem_ce, 0); check("R1 window blocks mem_we", mem_we, 0);
        @(posedge clk); #1; ce = 0; we = 0;
        rd(A_SEC, 8'h33, "R10 field write");
        mem_rdata = 8'hA5;
        rd(17'h1FFEF, 8'hA5, "R1 edge address passes through");
        @(posedge clk); #1;
        addr = 17'h1FFEF; ce = 1; re = 1;
        exp_q.push_back(8'hA5); tag_q.push_back("R1 mem read data");
        @(negedge clk);
        check("R1 mem_re", mem_re, 1);
        @(posedge clk); #1; ce = 0; re = 0;

        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule